// File: doc/BRIEF.md
# DisplayPort AUX Request Framer

This block turns one DisplayPort AUX channel request into the byte sequence that the channel transmitter sends, and then interprets the reply. The requester presents a 20-bit target address, a 4-bit request command and a length from 0 to 16 bytes. The block packs these into a 4-byte header. For write-class commands, the header is followed by payload bytes taken from a separate payload stream. Bytes leave on a valid/ready stream. After the last byte has gone out, the block waits for the reply: a status byte, then optional data bytes that end with a last marker.

The status byte decides the outcome. Three values mean failure, and each one is reported with its own result code. Any other value is a success, and its upper nibble is returned as the reply command. On a read, the reply data is passed to the requester, but never more bytes than the request asked for. On a write, the completion reports the payload length. The block takes one request at a time. It accepts a new request only once the previous completion has been signalled, and it can accept the next request in the same cycle as that completion pulse.

Top module: `aux_req_framer`

## Requirements
- R1: Header bytes go out in this order. Byte 0 is address[7:0]. Byte 1 is address[15:8]. Byte 2 is {command, address[19:16]}. Each header byte on tx_data is held stable while tx_ready is low.
- R2: Bits [3:0] of header byte 3 hold length-1 for a nonzero length, and 0 for length 0.
- R3: Bits [7:4] of header byte 3 hold a size code. The code is 3 for a zero-length (address-only) request, (4+length) mod 16 for a write, and 4 for any other request. All four header bytes are sent in every case.
- R4: A command is write-class when (command & 4'b1011) equals 4'b0000 or 4'b1000; bit 2 is ignored. For a write-class command, length payload bytes from pl_data follow the header. Every other command sends the header only.
- R5: A request with length above 16 is accepted and answered one cycle later by done_o with result 4 (bad length), count 0 and reply 0. No byte is sent.
- R6: A status byte equal to 1, 2 or 3 ends the transaction with result 1 (timeout), 2 (flags set) or 3 (failure) respectively. Count and reply are 0 in these cases, and no reply data is delivered.
- R7: For any other status byte, the result is 0 (success) and done_reply equals status[7:4].
- R8: On a read, rd_valid forwards only the first min(received, length) reply data bytes. done_count reports that number, and any further data bytes are dropped.
- R9: A successful write-class transaction reports done_count equal to the request length, whatever data the reply carries.
- R10: req_ready is low from the cycle after a request is accepted until the one-cycle done_o pulse. It is high during that pulse, so a waiting request is accepted in the same cycle.
- R11: During reset, req_ready is 1, and tx_valid and done_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_addr | input | 20 | Target address |
| req_cmd | input | 4 | Request command |
| req_len | input | 5 | Payload or read length in bytes |
| pl_valid | input | 1 | Payload byte offered |
| pl_ready | output | 1 | Payload byte consumed |
| pl_data | input | 8 | Payload byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Outgoing byte accepted |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Reply byte valid |
| rx_ready | output | 1 | Block waiting for reply bytes |
| rx_data | input | 8 | Reply byte (status first) |
| rx_last | input | 1 | Final reply byte |
| rd_valid | output | 1 | Delivered read data byte |
| rd_data | output | 8 | Delivered read data |
| done_o | output | 1 | One-cycle completion pulse |
| done_result | output | 3 | 0 ok, 1 timeout, 2 flags, 3 failure, 4 bad length |
| done_reply | output | 4 | Reply command nibble |
| done_count | output | 5 | Bytes transferred |

## Verification
Two events can fall in the same cycle: the completion pulse of one transaction and the acceptance of the next request. The bench provokes this by raising req_valid for a new request while the previous reply is still arriving. It then counts the cycles in which done_o, req_valid and req_ready are all high. The check passes if such a cycle occurred, the completion carries the earlier transaction's result, and the new header bytes follow in order.

// File: rtl/aux_frm_pkg.sv
package aux_frm_pkg;
    localparam int AUX_ADDR_W = 20;
    localparam int AUX_CMD_W  = 4;
    localparam int AUX_HDR_N  = 4;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_TIMEOUT = 3'd1,
        RES_FLAGS   = 3'd2,
        RES_FAIL    = 3'd3,
        RES_BADLEN  = 3'd4
    } aux_result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_WAIT,
        ST_DATA
    } aux_state_e;
endpackage

// File: rtl/aux_cmd_class.sv
module aux_cmd_class
    import aux_frm_pkg::*;
(
    input  logic [AUX_CMD_W-1:0] cmd_i,
    output logic                 is_wr_o
);
    localparam logic [AUX_CMD_W-1:0] CLASS_MASK = 4'b1011;
    logic [AUX_CMD_W-1:0] masked;

    always_comb begin
        masked  = cmd_i & CLASS_MASK;
        is_wr_o = (masked == 4'b0000) || (masked == 4'b1000);
    end
endmodule

// File: rtl/aux_hdr_pack.sv
module aux_hdr_pack
    import aux_frm_pkg::*;
#(
    parameter int LEN_W = 5
) (
    input  logic [AUX_ADDR_W-1:0]     addr_i,
    input  logic [AUX_CMD_W-1:0]      cmd_i,
    input  logic [LEN_W-1:0]          len_i,
    input  logic                      is_wr_i,
    input  logic [1:0]                sel_i,
    output logic [7:0]                byte_o
);
    localparam logic [3:0] BARE_CODE = 4'd3;
    localparam logic [3:0] HDR_SIZE  = 4'd4;

    logic [AUX_HDR_N-1:0][7:0] hdr;
    logic [LEN_W:0]            total;
    logic [3:0]                size_nib;
    logic [LEN_W-1:0]          len_m1;

    always_comb begin
        total  = (LEN_W+1)'(AUX_HDR_N) + {1'b0, len_i};
        len_m1 = (len_i == '0) ? '0 : len_i - 1'b1;
        if (len_i == '0) begin
            size_nib = BARE_CODE;
        end else if (is_wr_i) begin
            size_nib = total[3:0];
        end else begin
            size_nib = HDR_SIZE;
        end
        hdr[0] = addr_i[7:0];
        hdr[1] = addr_i[15:8];
        hdr[2] = {cmd_i, addr_i[19:16]};
        hdr[3] = {size_nib, len_m1[3:0]};
        byte_o = hdr[sel_i];
    end
endmodule

// File: rtl/aux_reply_class.sv
module aux_reply_class
    import aux_frm_pkg::*;
(
    input  logic [7:0]  status_i,
    output logic        fail_o,
    output aux_result_e result_o,
    output logic [3:0]  reply_o
);
    always_comb begin
        fail_o   = 1'b1;
        reply_o  = 4'd0;
        unique case (status_i)
            8'd1:    result_o = RES_TIMEOUT;
            8'd2:    result_o = RES_FLAGS;
            8'd3:    result_o = RES_FAIL;
            default: begin
                result_o = RES_OK;
                fail_o   = 1'b0;
                reply_o  = status_i[7:4];
            end
        endcase
    end
endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
    import aux_frm_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [AUX_ADDR_W-1:0] req_addr,
    input  logic [AUX_CMD_W-1:0]  req_cmd,
    input  logic [LEN_W-1:0]      req_len,
    input  logic                  pl_valid,
    output logic                  pl_ready,
    input  logic [7:0]            pl_data,
    output logic                  tx_valid,
    input  logic                  tx_ready,
    output logic [7:0]            tx_data,
    input  logic                  rx_valid,
    output logic                  rx_ready,
    input  logic [7:0]            rx_data,
    input  logic                  rx_last,
    output logic                  rd_valid,
    output logic [7:0]            rd_data,
    output logic                  done_o,
    output logic [2:0]            done_result,
    output logic [3:0]            done_reply,
    output logic [LEN_W-1:0]      done_count
);
    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);
    localparam logic [1:0]       HDR_LAST  = 2'(AUX_HDR_N - 1);

    typedef struct packed {
        aux_state_e             st;
        logic [AUX_ADDR_W-1:0]  addr;
        logic [AUX_CMD_W-1:0]   cmd;
        logic [LEN_W-1:0]       len;
        logic                   wr;
        logic [LEN_W-1:0]       idx;
        logic [LEN_W-1:0]       rcnt;
        logic [3:0]             rpl;
        logic                   done;
        aux_result_e            res;
        logic [LEN_W-1:0]       cnt;
    } frm_state_t;

    frm_state_t q, d;

    logic        req_is_wr;
    logic [7:0]  hdr_byte;
    logic        st_fail;
    aux_result_e st_res;
    logic [3:0]  st_rpl;
    logic        take;
    logic        in_hdr;
    logic        in_wait;

    aux_cmd_class u_cls (
        .cmd_i   (req_cmd),
        .is_wr_o (req_is_wr)
    );

    aux_hdr_pack #(.LEN_W(LEN_W)) u_hdr (
        .addr_i  (q.addr),
        .cmd_i   (q.cmd),
        .len_i   (q.len),
        .is_wr_i (q.wr),
        .sel_i   (q.idx[1:0]),
        .byte_o  (hdr_byte)
    );

    aux_reply_class u_rpl (
        .status_i (rx_data),
        .fail_o   (st_fail),
        .result_o (st_res),
        .reply_o  (st_rpl)
    );

    always_comb begin
        in_hdr  = (q.st == ST_HDR);
        in_wait = (q.st == ST_WAIT);
        take    = (q.st == ST_DATA) && rx_valid && !q.wr && (q.rcnt < q.len);

        req_ready = (q.st == ST_IDLE);
        tx_valid  = in_hdr || ((q.st == ST_PAY) && pl_valid);
        tx_data   = in_hdr ? hdr_byte : ((q.st == ST_PAY) ? pl_data : 8'd0);
        pl_ready  = (q.st == ST_PAY) && tx_ready;
        rx_ready  = in_wait || (q.st == ST_DATA);
        rd_valid  = take;
        rd_data   = rx_data;

        done_o      = q.done;
        done_result = q.res;
        done_reply  = q.rpl;
        done_count  = q.cnt;
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_len > LEN_LIMIT) begin
                        d.done = 1'b1;
                        d.res  = RES_BADLEN;
                        d.cnt  = '0;
                        d.rpl  = '0;
                    end else begin
                        d.st   = ST_HDR;
                        d.addr = req_addr;
                        d.cmd  = req_cmd;
                        d.len  = req_len;
                        d.wr   = req_is_wr;
                        d.idx  = '0;
                        d.rcnt = '0;
                    end
                end
            end
            ST_HDR: begin
                if (tx_ready) begin
                    if (q.idx[1:0] == HDR_LAST) begin
                        d.idx = '0;
                        d.st  = (q.wr && q.len != '0) ? ST_PAY : ST_WAIT;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_PAY: begin
                if (pl_valid && tx_ready) begin
                    if (q.idx == q.len - 1'b1) begin
                        d.st  = ST_WAIT;
                        d.idx = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (rx_valid) begin
                    if (st_fail) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.res  = st_res;
                        d.cnt  = '0;
                        d.rpl  = '0;
                    end else begin
                        d.rpl = st_rpl;
                        if (rx_last) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                            d.res  = RES_OK;
                            d.cnt  = q.wr ? q.len : '0;
                        end else begin
                            d.st = ST_DATA;
                        end
                    end
                end
            end
            ST_DATA: begin
                if (rx_valid) begin
                    if (take) begin
                        d.rcnt = q.rcnt + 1'b1;
                    end
                    if (rx_last) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.res  = RES_OK;
                        d.cnt  = q.wr ? q.len : d.rcnt;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, res: RES_OK, default: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/aux_req_framer_chk.sv
module aux_req_framer_chk
    import aux_frm_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LEN_W-1:0] req_len,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic [7:0]       rx_data,
    input logic             rd_valid,
    input logic             done_o,
    input logic [2:0]       done_result,
    input logic [3:0]       done_reply,
    input logic [LEN_W-1:0] done_count,
    input logic             in_hdr,
    input logic             in_wait
);
    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);

    AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        in_hdr && !tx_ready |=> tx_valid && $stable(tx_data)); // R1

    AST_BADLEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_len > LEN_LIMIT) |=> done_o && done_result == 3'd4 && !tx_valid); // R5

    AST_TIMEOUT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait && rx_valid && rx_data == 8'd1 |=> done_o && done_result == 3'd1); // R6

    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && done_result != 3'd0 |-> done_count == '0 && done_reply == 4'd0); // R6

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> done_count <= LEN_LIMIT); // R8

    AST_RD_IN_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rx_valid && rx_ready); // R8

    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !req_ready); // R10

    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> req_ready); // R10
endmodule

bind aux_req_framer aux_req_framer_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_len     (req_len),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_data     (rx_data),
    .rd_valid    (rd_valid),
    .done_o      (done_o),
    .done_result (done_result),
    .done_reply  (done_reply),
    .done_count  (done_count),
    .in_hdr      (in_hdr),
    .in_wait     (in_wait)
);

// File: tb/test_aux_req_framer.sv
module test_aux_req_framer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic [4:0]  req_len = '0;
    logic        pl_valid = 1'b0;
    logic        pl_ready;
    logic [7:0]  pl_data = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        done_o;
    logic [2:0]  done_result;
    logic [3:0]  done_reply;
    logic [4:0]  done_count;

    aux_req_framer i_aux_req_framer (.*);

    int n_chk = 0;
    int n_err = 0;
    int overlap_seen = 0;
    int cyc = 0;
    bit bp_en = 1'b0;
    bit pl_fire = 1'b0;

    logic [7:0] tx_exp[$];
    string      tx_tag[$];
    logic [7:0] rd_exp[$];
    logic [7:0] pl_src[$];
    logic [2:0] dres_exp[$];
    logic [3:0] drpl_exp[$];
    logic [4:0] dcnt_exp[$];
    string      dtag_exp[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // outgoing readiness, optionally throttled
    always @(posedge clk) begin
        #1;
        cyc++;
        tx_ready = !bp_en || (cyc % 3 != 0);
    end

    // payload source
    always @(negedge clk) pl_fire = pl_valid && pl_ready;
    always @(posedge clk) begin
        #1;
        if (pl_fire && pl_src.size() > 0) void'(pl_src.pop_front());
        pl_valid = (pl_src.size() > 0);
        pl_data  = (pl_src.size() > 0) ? pl_src[0] : 8'd0;
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                if (tx_exp.size() == 0) begin
                    chk(1'b0, "R5", "unexpected tx byte", tx_data, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = tx_exp.pop_front();
                    t = tx_tag.pop_front();
                    chk(tx_data == e, t, "tx byte", tx_data, e);
                end
            end
            if (rd_valid) begin
                if (rd_exp.size() == 0) begin
                    chk(1'b0, "R8", "unexpected read byte", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    e = rd_exp.pop_front();
                    chk(rd_data == e, "R8", "read byte", rd_data, e);
                end
            end
            if (done_o) begin
                if (dres_exp.size() == 0) begin
                    chk(1'b0, "R10", "unexpected done", done_result, 0);
                end else begin
                    logic [2:0] er;
                    logic [3:0] ep;
                    logic [4:0] ec;
                    string t;
                    er = dres_exp.pop_front();
                    ep = drpl_exp.pop_front();
                    ec = dcnt_exp.pop_front();
                    t  = dtag_exp.pop_front();
                    chk(done_result == er, t, "result", done_result, er);
                    chk(done_reply == ep, "R7", "reply nibble", done_reply, ep);
                    chk(done_count == ec, t, "count", done_count, ec);
                end
                if (req_valid && req_ready) overlap_seen++;
            end
        end
    end

    task automatic expect_done(input logic [2:0] r, input logic [3:0] p,
                               input logic [4:0] c, input string t);
        dres_exp.push_back(r);
        drpl_exp.push_back(p);
        dcnt_exp.push_back(c);
        dtag_exp.push_back(t);
    endtask

    task automatic send_req(input logic [19:0] addr, input logic [3:0] cmd,
                            input logic [4:0] len, input logic [7:0] seed);
        bit wr;
        logic [3:0] up;
        logic [3:0] lo;
        wr = ((cmd & 4'hB) == 4'h0) || ((cmd & 4'hB) == 4'h8);
        if (len > 5'd16) begin
            expect_done(3'd4, 4'd0, 5'd0, "R5");
        end else begin
            up = (len == 0) ? 4'd3 : (wr ? 4'((4 + len) % 16) : 4'd4);
            lo = (len == 0) ? 4'd0 : 4'(len - 1);
            tx_exp.push_back(addr[7:0]);      tx_tag.push_back("R1");
            tx_exp.push_back(addr[15:8]);     tx_tag.push_back("R1");
            tx_exp.push_back({cmd, addr[19:16]}); tx_tag.push_back("R1");
            tx_exp.push_back({up, lo});       tx_tag.push_back("R3");
            if (wr) begin
                for (int i = 0; i < len; i++) begin
                    tx_exp.push_back(8'(seed + i));
                    tx_tag.push_back("R4");
                    pl_src.push_back(8'(seed + i));
                end
            end
        end
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_addr  = addr;
        req_cmd   = cmd;
        req_len   = len;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic send_reply(input logic [7:0] status, input int ndata,
                              input logic [7:0] seed, input int rlen, input bit wr);
        int n;
        int keep;
        if (status >= 8'd1 && status <= 8'd3) begin
            n = 0;
            expect_done(status[2:0], 4'd0, 5'd0, "R6");
        end else begin
            n = ndata;
            keep = (ndata < rlen) ? ndata : rlen;
            if (wr) begin
                expect_done(3'd0, status[7:4], 5'(rlen), "R9");
            end else begin
                expect_done(3'd0, status[7:4], 5'(keep), "R8");
                for (int i = 0; i < keep; i++) rd_exp.push_back(8'(seed + i));
            end
        end
        @(posedge clk); #1;
        for (int i = 0; i <= n; i++) begin
            rx_valid = 1'b1;
            rx_data  = (i == 0) ? status : 8'(seed + i - 1);
            rx_last  = (i == n);
            do @(negedge clk); while (!rx_ready);
            @(posedge clk); #1;
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(req_ready == 1'b1, "R11", "req_ready in reset", req_ready, 1);
        chk(tx_valid == 1'b0, "R11", "tx_valid in reset", tx_valid, 0);
        chk(done_o == 1'b0, "R11", "done in reset", done_o, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // native write, 3 bytes (R2, R3, R4, R9)
        send_req(20'h12345, 4'h8, 5'd3, 8'h10);
        send_reply(8'h00, 0, 8'h00, 3, 1'b1);

        // native read, 16 asked, 18 returned (R8 clamp)
        send_req(20'hABCDE, 4'h9, 5'd16, 8'h00);
        send_reply(8'h00, 18, 8'h40, 16, 1'b0);

        // read 5 asked, 3 returned; reply nibble 1 (R7, R8)
        send_req(20'h00F0F, 4'h1, 5'd5, 8'h00);
        send_reply(8'h10, 3, 8'h80, 5, 1'b0);

        // address-only write with bit 2 set (R3, R4, R7)
        send_req(20'h00050, 4'h4, 5'd0, 8'h00);
        send_reply(8'h20, 0, 8'h00, 0, 1'b1);

        // address-only read, data in reply dropped (R3, R8)
        send_req(20'h00777, 4'h9, 5'd0, 8'h00);
        send_reply(8'h00, 2, 8'h90, 0, 1'b0);

        // I2C write 12 bytes: size code wraps to 0 (R3)
        send_req(20'h00A0B, 4'h0, 5'd12, 8'h30);
        send_reply(8'h00, 0, 8'h00, 12, 1'b1);

        // failure codes (R6)
        send_req(20'h11111, 4'h5, 5'd1, 8'h00);
        send_reply(8'h01, 0, 8'h00, 1, 1'b0);
        send_req(20'h22222, 4'h9, 5'd2, 8'h00);
        send_reply(8'h02, 0, 8'h00, 2, 1'b0);
        send_req(20'h33333, 4'h8, 5'd1, 8'h55);
        send_reply(8'h03, 0, 8'h00, 1, 1'b1);

        // oversize length rejected (R5)
        send_req(20'h44444, 4'h8, 5'd20, 8'h00);
        repeat (3) @(negedge clk);
        chk(tx_exp.size() == 0, "R5", "no bytes after oversize", tx_exp.size(), 0);

        // throttled write, 7 bytes (R1 hold under backpressure)
        bp_en = 1'b1;
        send_req(20'h5A5A5, 4'hC, 5'd7, 8'hC0);
        send_reply(8'h00, 0, 8'h00, 7, 1'b1);
        bp_en = 1'b0;

        // completion and next acceptance in the same cycle (R10)
        send_req(20'h60606, 4'h9, 5'd2, 8'h00);
        fork
            send_reply(8'h00, 2, 8'hE0, 2, 1'b0);
            send_req(20'h70707, 4'h9, 5'd1, 8'h00);
        join
        send_reply(8'h30, 1, 8'hF0, 1, 1'b0);

        repeat (6) @(negedge clk);
        chk(overlap_seen > 0, "R10", "done with same-cycle accept", overlap_seen, 1);
        chk(tx_exp.size() == 0, "R4", "tx queue drained", tx_exp.size(), 0);
        chk(rd_exp.size() == 0, "R8", "read queue drained", rd_exp.size(), 0);
        chk(dres_exp.size() == 0, "R10", "done queue drained", dres_exp.size(), 0);
        finish_run();
    end
endmodule